// File: doc/BRIEF.md
# Indexed Window Access to an Interrupt Redirection Table

This block gives a host on a memory-mapped bus access to a file of interrupt redirection entries through two 32-bit registers: a selector and a data window. The host first writes an 8-bit register offset into the selector. Reads and writes of the window then act on the internal register that the selector names. Each redirection entry is 64 bits wide and is reached through two neighbouring offsets. The even offset holds the low word and the odd offset holds the high word. Entry 0 begins at offset 10h. Offset 00h holds a read-only identification word and offset 01h holds a read-only version word.

The two host registers sit at a base address that can be moved at run time. The base is taken with its four low bits cleared, which aligns it to 128 bits. The selector is at base+00h and the window at base+10h. Read data is registered and appears in the cycle after the read strobe. The whole table is also driven out as a flat vector so that interrupt delivery logic can use it.

Top module: `redir_window_port`

## Requirements
- R1: After reset the selector holds 00h and busRdata is zero. Every entry holds 64'h0000_0000_0001_0000: mask bit 16 is set and every other bit is clear.
- R2: A write at exactly base+00h stores busWdata[7:0] in the selector. A read there returns the selector in bits [7:0] with zeroes in bits [31:8].
- R3: A window write with selector value 10h+2i replaces bits [31:0] of entry i. With 11h+2i it replaces bits [63:32]. The other half of entry i and all other entries keep their values.
- R4: A window read returns the half-entry that the selector names. The data appears on busRdata in the cycle after busRe is sampled.
- R5: A window read at offset 00h returns IDENT_VALUE. At offset 01h it returns {8'h00, NUM_ENTRIES-1, 8'h00, VERSION}. Window writes to these two offsets change nothing.
- R6: A selector value of 02h to 0Fh, or above 0Fh+2*NUM_ENTRIES, makes window reads return zero and window writes change no entry.
- R7: An access whose byte offset from the base is neither exactly 00h nor exactly 10h has no effect on the selector or the table, and a read of it returns zero.
- R8: Changing baseAddr moves both registers at once, and baseAddr[3:0] is ignored.
- R9: busRdata is zero in every cycle that does not follow a sampled read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | ADDR_W | Relocatable base; bits [3:0] ignored |
| busAddr | input | ADDR_W | Host byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| redirTable | output | NUM_ENTRIES*64 | All entries; entry i at bits [64i+63:64i] |

## Verification
Every entry receives its own low and high pattern, and the full table is compared after each write. This shows whether the half-select and entry-index decode hit exactly one word. Writes to read-only, unmapped and past-the-end offsets show that writes are gated by the selector's range. Writes at stray addresses inside and outside the decoded span show that the address decode is exact. Moving the base to a new address with nonzero low bits shows that relocation follows baseAddr and drops its four low bits.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam int REG_W = 32;
  localparam int ENTRY_W = 64;
  localparam int MASK_BIT = 16;
  localparam logic [7:0] OFF_IDENT = 8'h00;
  localparam logic [7:0] OFF_VER = 8'h01;
  localparam logic [7:0] OFF_TABLE = 8'h10;

  typedef struct packed {
    logic selWr;
    logic winWr;
    logic rdSel;
    logic rdWin;
  } ctrlStrobes_t;
endpackage

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import redir_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output ctrlStrobes_t      strobes
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(15);
  localparam logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16);

  logic [ADDR_W-1:0] alignedBase;
  logic [ADDR_W-1:0] offset;
  logic selHit;
  logic winHit;

  always_comb begin
    alignedBase = baseAddr & ALIGN_MASK;
    offset = busAddr - alignedBase;
    selHit = (offset == '0);
    winHit = (offset == WIN_OFF);
    strobes.selWr = busWe && selHit;
    strobes.winWr = busWe && winHit;
    strobes.rdSel = busRe && selHit;
    strobes.rdWin = busRe && winHit;
  end
endmodule

// File: rtl/redir_datapath.sv
module redir_datapath
  import redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter logic [31:0] IDENT_VALUE = 32'h0A00_0000,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobes_t                   strobes,
  input  logic [REG_W-1:0]               wdata,
  output logic [REG_W-1:0]               rdata,
  output logic [7:0]                     selReg,
  output logic [NUM_ENTRIES*ENTRY_W-1:0] tableFlat
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int LAST_OFF = 16 + 2 * NUM_ENTRIES - 1;
  localparam logic [ENTRY_W-1:0] RESET_ENTRY = ENTRY_W'(1) << MASK_BIT;
  localparam logic [REG_W-1:0] VER_WORD = {8'h00, 8'(NUM_ENTRIES - 1), 8'h00, VERSION};

  logic [ENTRY_W-1:0] entries [NUM_ENTRIES];
  logic [7:0] tblOffset;
  logic [IDX_W-1:0] entIdx;
  logic hiHalf;
  logic inTable;
  logic [REG_W-1:0] winValue;

  always_comb begin
    tblOffset = selReg - OFF_TABLE;
    entIdx = tblOffset[IDX_W:1];
    hiHalf = tblOffset[0];
    inTable = (selReg >= OFF_TABLE) && (selReg <= 8'(LAST_OFF));
  end

  always_ff @(posedge clk) begin
    if (!rstN) selReg <= '0;
    else if (strobes.selWr) selReg <= wdata[7:0];
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[g] <= RESET_ENTRY;
      end else if (strobes.winWr && inTable && entIdx == IDX_W'(g)) begin
        if (hiHalf) entries[g][63:32] <= wdata;
        else entries[g][31:0] <= wdata;
      end
    end
    assign tableFlat[g*ENTRY_W +: ENTRY_W] = entries[g];
  end

  always_comb begin
    if (selReg == OFF_IDENT) winValue = IDENT_VALUE;
    else if (selReg == OFF_VER) winValue = VER_WORD;
    else if (inTable) winValue = hiHalf ? entries[entIdx][63:32] : entries[entIdx][31:0];
    else winValue = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (strobes.rdSel) rdata <= {24'h0, selReg};
    else if (strobes.rdWin) rdata <= winValue;
    else rdata <= '0;
  end
endmodule

// File: rtl/redir_window_port.sv
module redir_window_port
  import redir_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_ENTRIES = 16,
  parameter logic [31:0] IDENT_VALUE = 32'h0A00_0000,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWe,
  input  logic [31:0]                 busWdata,
  input  logic                        busRe,
  output logic [31:0]                 busRdata,
  output logic [NUM_ENTRIES*64-1:0]   redirTable
);
  ctrlStrobes_t strobes;
  logic [7:0] selReg;

  redir_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .baseAddr(baseAddr),
    .busAddr(busAddr),
    .busWe(busWe),
    .busRe(busRe),
    .strobes(strobes)
  );

  redir_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDENT_VALUE(IDENT_VALUE),
    .VERSION(VERSION)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .wdata(busWdata),
    .rdata(busRdata),
    .selReg(selReg),
    .tableFlat(redirTable)
  );
endmodule

// File: rtl/redir_window_chk.sv
module redir_window_chk #(
  parameter int ADDR_W = 32,
  parameter int NUM_ENTRIES = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [ADDR_W-1:0]         baseAddr,
  input logic [ADDR_W-1:0]         busAddr,
  input logic                      busWe,
  input logic [7:0]                wdataLow,
  input logic                      busRe,
  input logic [31:0]               busRdata,
  input logic [7:0]                selReg,
  input logic [NUM_ENTRIES*64-1:0] redirTable
);
  localparam int LAST_OFF = 16 + 2 * NUM_ENTRIES - 1;
  logic [ADDR_W-1:0] offs;
  logic atSel;
  logic atWin;
  logic selUnmapped;

  assign offs = busAddr - (baseAddr & ~ADDR_W'(15));
  assign atSel = (offs == '0);
  assign atWin = (offs == ADDR_W'(16));
  assign selUnmapped = (selReg > 8'h01 && selReg < 8'h10) || (selReg > 8'(LAST_OFF));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> busRdata == '0);
  a_r2_sel_capture: assert property (@(posedge clk) disable iff (!rstN)
    busWe && atSel |=> selReg == $past(wdataLow));
  a_r2_sel_readback: assert property (@(posedge clk) disable iff (!rstN)
    busRe && atSel |=> busRdata == {24'h0, $past(selReg)});
  a_r7_stray_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    busWe && !atSel && !atWin |=> $stable(selReg) && $stable(redirTable));
  a_r6_unmapped_no_write: assert property (@(posedge clk) disable iff (!rstN)
    busWe && atWin && selUnmapped |=> $stable(redirTable));
endmodule

bind redir_window_port redir_window_chk #(
  .ADDR_W(ADDR_W),
  .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .baseAddr(baseAddr),
  .busAddr(busAddr),
  .busWe(busWe),
  .wdataLow(busWdata[7:0]),
  .busRe(busRe),
  .busRdata(busRdata),
  .selReg(selReg),
  .redirTable(redirTable)
);

// File: tb/sim_redir_window_port.sv
`timescale 1ns/1ps
module sim_redir_window_port;
  localparam int N = 16;
  localparam logic [31:0] IDENT = 32'h0A00_0000;
  localparam logic [31:0] VERW = 32'h000F_0011;

  logic clk = 0;
  logic rstN = 0;
  logic [31:0] baseAddr = 32'hFEC0_0000;
  logic [31:0] busAddr = '0;
  logic busWe = 0;
  logic [31:0] busWdata = '0;
  logic busRe = 0;
  logic [31:0] busRdata;
  logic [N*64-1:0] redirTable;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] model [N];
  logic [31:0] expQ [$];
  string tagQ [$];

  always #5 clk = ~clk;

  redir_window_port #(.NUM_ENTRIES(N)) u0 (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRe(busRe), .busRdata(busRdata),
    .redirTable(redirTable)
  );

  function automatic logic [N*64-1:0] packModel();
    logic [N*64-1:0] v;
    for (int i = 0; i < N; i++) v[i*64 +: 64] = model[i];
    return v;
  endfunction

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRe = 1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 0;
  endtask

  task automatic checkTable(input string tag);
    @(negedge clk);
    checks++;
    if (redirTable !== packModel()) begin
      errors++;
      $display("FAIL %s table actual=%h expected=%h", tag, redirTable, packModel());
    end
  endtask

  // monitor: pop an expected item for every sampled read strobe
  initial begin
    forever begin
      logic sampledRe;
      @(posedge clk);
      sampledRe = busRe;
      #2;
      if (sampledRe && rstN) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty actual=%h expected=none", busRdata);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          if (busRdata !== e) begin
            errors++;
            $display("FAIL %s read actual=%h expected=%h", t, busRdata, e);
          end
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 64'h0000_0000_0001_0000;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    checks++;
    if (busRdata !== 32'h0) begin
      errors++; $display("FAIL R1 rdata actual=%h expected=0", busRdata);
    end
    checkTable("R1");
    rd(baseAddr, 32'h0, "R1 selector");
    rd(baseAddr + 16, IDENT, "R1 ident");
    // R2 selector write and readback
    wr(baseAddr, 32'h1234_56AB);
    rd(baseAddr, 32'h0000_00AB, "R2");
    // R5 read-only words
    wr(baseAddr, 32'h00);
    wr(baseAddr + 16, 32'hFFFF_FFFF);
    rd(baseAddr + 16, IDENT, "R5 ident");
    wr(baseAddr, 32'h01);
    wr(baseAddr + 16, 32'h0);
    rd(baseAddr + 16, VERW, "R5 version");
    checkTable("R5");
    // R4 reset value of entry 0 through window
    wr(baseAddr, 32'h10);
    rd(baseAddr + 16, 32'h0001_0000, "R4 e0 low");
    wr(baseAddr, 32'h11);
    rd(baseAddr + 16, 32'h0, "R4 e0 high");
    // R3 every entry, low then high, whole table each time
    for (int i = 0; i < N; i++) begin
      wr(baseAddr, 32'h10 + 2 * i);
      wr(baseAddr + 16, 32'hA500_0000 + i);
      model[i][31:0] = 32'hA500_0000 + i;
      checkTable("R3 low");
      wr(baseAddr, 32'h11 + 2 * i);
      wr(baseAddr + 16, 32'h5A00_0000 + (i << 8));
      model[i][63:32] = 32'h5A00_0000 + (i << 8);
      checkTable("R3 high");
    end
    // R3 rewrite high only, low kept
    wr(baseAddr, 32'h13);
    wr(baseAddr + 16, 32'hDEAD_BEEF);
    model[1][63:32] = 32'hDEAD_BEEF;
    checkTable("R3 half");
    // R4 read back several entries
    for (int i = 0; i < N; i += 5) begin
      wr(baseAddr, 32'h10 + 2 * i);
      rd(baseAddr + 16, model[i][31:0], "R4 low");
      wr(baseAddr, 32'h11 + 2 * i);
      rd(baseAddr + 16, model[i][63:32], "R4 high");
    end
    // R6 unmapped selector values
    wr(baseAddr, 32'h10 + 2 * N);
    wr(baseAddr + 16, 32'h1111_1111);
    rd(baseAddr + 16, 32'h0, "R6 past end");
    checkTable("R6 past end");
    wr(baseAddr, 32'h05);
    wr(baseAddr + 16, 32'h2222_2222);
    rd(baseAddr + 16, 32'h0, "R6 gap");
    checkTable("R6 gap");
    // R7 stray addresses
    wr(baseAddr, 32'h10);
    wr(baseAddr + 4, 32'h99);
    wr(baseAddr + 32, 32'h77);
    wr(baseAddr + 17, 32'h3333_3333);
    rd(baseAddr, 32'h10, "R7 selector kept");
    rd(baseAddr + 4, 32'h0, "R7 stray read");
    rd(baseAddr + 18, 32'h0, "R7 unaligned read");
    checkTable("R7");
    // R8 relocation with low bits set
    baseAddr = 32'hFEC0_1007;
    rd(32'hFEC0_1000, 32'h10, "R8 new base");
    rd(32'hFEC0_1010, model[0][31:0], "R8 new window");
    rd(32'hFEC0_0000, 32'h0, "R8 old base");
    wr(32'hFEC0_0000, 32'h20);
    rd(32'hFEC0_1000, 32'h10, "R8 old base write");
    // R9 idle cycle after a read
    @(negedge clk);
    checks++;
    if (busRdata !== 32'h0) begin
      errors++; $display("FAIL R9 idle actual=%h expected=0", busRdata);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++; $display("FAIL scoreboard left actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule